// File: doc/BRIEF.md
# In-Order Issue Slot Controller

This block does the issue-slot accounting for an in-order superscalar front end. Each clock cycle counts as one issue cycle, and each cycle starts with a full budget of `WIDTH` slots. Up to `SLOTS` instruction descriptors are offered on parallel lanes in program order. A descriptor carries a micro-op count, a flag that says it must open a cycle, and a flag that says it must close one. The block accepts the longest in-order prefix of lanes that fits the rules. Acceptance is combinational and acts as the ready half of a one-cycle valid/ready handshake on each lane.

Some instructions carry more micro-ops than the whole issue width. Such an instruction is still taken, and it spills over: the block fills the slots that remain in the current cycle and records the rest as a carry-over. That carry-over then takes slots first in the following cycles until it is used up. While it is still being used up, no new instruction enters. A stall input, driven by outside hazard logic, blocks new acceptance for as long as it is held. Hazard detection, register files, execution and retirement are handled by other blocks.

Top module: `issue_slot_ctrl`

## Requirements
- R1: At the start of every cycle the slot budget is reloaded to `WIDTH` and the per-cycle issued count is cleared. For example, four 1-micro-op instructions are all accepted in one cycle when `WIDTH` is 4, and they are accepted again in the next cycle.
- R2: While `stall_i` is high, no lane is accepted, whatever the remaining budget or the instruction size.
- R3: An instruction whose micro-op count is at most `WIDTH` is accepted only if the remaining budget is at least its micro-op count. One that needs exactly the full width fits in an empty cycle.
- R4: An instruction whose micro-op count is above `WIDTH` is accepted whatever the remaining budget, including a budget of zero.
- R5: A lane flagged begin-group is accepted only when no micro-op has been issued yet in the current cycle. Slots taken by a carry-over that finishes in this cycle do not count as issued.
- R6: After a lane flagged end-group is accepted, the remaining budget of the cycle becomes zero, so no later lane of that cycle is accepted.
- R7: When an accepted instruction needs more micro-ops than the remaining budget, the excess becomes a carry-over. No later lane is accepted in that cycle, and `carry_busy_o` is high in the next cycle.
- R8: At the start of a cycle, a carry-over larger than `WIDTH` takes the whole budget and shrinks by `WIDTH`. It stays pending, and no lane is accepted in that cycle.
- R9: A carry-over of at most `WIDTH` is used up at the start of a cycle. The lanes of that cycle then get the slots that remain. If the carried instruction was flagged end-group, they get no slots.
- R10: `carry_done_o` is high in exactly the cycle in which a pending carry-over is used up, and that instruction counts as complete only then.
- R11: Acceptance is in order. A lane that is invalid or rejected blocks every later lane in the same cycle.
- R12: A carry-over keeps being used up while `stall_i` is high.
- R13: `overflow_o` goes high if the micro-ops issued in a cycle exceed `WIDTH`. A correct design never raises it.
- R14: An active-low reset drops any pending carry-over, so `carry_busy_o` and `carry_done_o` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one edge per issue cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Outside stall; blocks new acceptance |
| in_valid_i | input | SLOTS | Per-lane descriptor valid; lane 0 is oldest |
| in_uops_i | input | SLOTS*UOPW | Per-lane micro-op count; lane i at bits [i*UOPW +: UOPW] |
| in_begin_i | input | SLOTS | Per-lane flag: must be first in its cycle |
| in_end_i | input | SLOTS | Per-lane flag: closes its cycle |
| accept_o | output | SLOTS | Per-lane acceptance in the current cycle |
| carry_busy_o | output | 1 | A carry-over is pending at the start of this cycle |
| carry_done_o | output | 1 | The pending carry-over is used up in this cycle |
| overflow_o | output | 1 | Issued micro-ops in this cycle exceed WIDTH |

## Verification
The test patterns come in several kinds, and each kind separates one rule from the others:
- Runs of small instructions that fill the width exactly, or leave one slot short, separate the budget rule from the ordering rule.
- Begin-group and end-group flags placed on early or late lanes show whether the issued count or the remaining budget is the quantity tested.
- Wide instructions offered into empty, half-used and closed cycles, with carry-overs of one, two and more cycles, separate a carry that holds the whole cycle from one that only takes part of it. They also test the end-group flag of a carried instruction.
- A stall applied while a carry-over is pending shows that stalling and using up a carry-over are independent.
- A reset taken in the middle of a carry-over shows that the pending state is dropped.

// File: rtl/issue_slot_pkg.sv
package issue_slot_pkg;

   // Phase of the carry-over tracker at the start of a cycle
   typedef enum logic [1:0] {
      CARRY_NONE = 2'd0,   // nothing pending, full budget
      CARRY_HOLD = 2'd1,   // pending count exceeds the width
      CARRY_LAST = 2'd2    // pending count drains this cycle
   } carry_phase_e;

   function automatic int unsigned slot_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned slot_clog2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/issue_slot_carry.sv
module issue_slot_carry
   import issue_slot_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned UOPW  = 4,
   parameter int unsigned CW    = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            new_vld_i,
   input  logic [UOPW-1:0] new_cnt_i,
   input  logic            new_end_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            hold_o,
   output logic [CW-1:0]   bw_o
);

   localparam logic [CW-1:0] WIDTH_C = CW'(WIDTH);

   logic [UOPW-1:0] cnt_q, cnt_d;
   logic            end_q, end_d;
   logic [CW-1:0]   cnt_w;
   carry_phase_e    phase;

   assign cnt_w = CW'(cnt_q);

   always_comb begin
      if (cnt_q == '0)          phase = CARRY_NONE;
      else if (cnt_w > WIDTH_C) phase = CARRY_HOLD;
      else                      phase = CARRY_LAST;
   end

   always_comb begin
      unique case (phase)
         CARRY_HOLD: bw_o = '0;
         CARRY_LAST: bw_o = end_q ? '0 : (WIDTH_C - cnt_w);
         default:    bw_o = WIDTH_C;
      endcase
   end

   assign busy_o = (phase != CARRY_NONE);
   assign done_o = (phase == CARRY_LAST);
   assign hold_o = (phase == CARRY_HOLD);

   always_comb begin
      cnt_d = '0;
      end_d = 1'b0;
      if (new_vld_i) begin
         cnt_d = new_cnt_i;
         end_d = new_end_i;
      end else if (phase == CARRY_HOLD) begin
         cnt_d = UOPW'(cnt_w - WIDTH_C);
         end_d = end_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         end_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         end_q <= end_d;
      end
   end

   // R8: a carry still larger than the width stays pending into the next cycle
   p_hold_persists_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_o |=> busy_o);
   // R9: a carry that drains with no new spill leaves nothing pending
   p_last_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !new_vld_i) |=> !busy_o);
   // R7: no new spill can be created while a carry is held
   p_no_spill_in_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_o |-> !new_vld_i);

endmodule

// File: rtl/issue_slot_lane.sv
module issue_slot_lane #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned UOPW  = 4,
   parameter int unsigned CW    = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            go_i,
   input  logic            valid_i,
   input  logic [UOPW-1:0] uops_i,
   input  logic            begin_i,
   input  logic            end_i,
   input  logic [CW-1:0]   bw_i,
   input  logic [CW-1:0]   iss_i,
   output logic            acc_o,
   output logic            go_o,
   output logic [CW-1:0]   bw_o,
   output logic [CW-1:0]   iss_o,
   output logic            spill_o,
   output logic [UOPW-1:0] spill_cnt_o,
   output logic            spill_end_o
);

   localparam logic [CW-1:0] WIDTH_C = CW'(WIDTH);

   logic [CW-1:0] need;
   logic          wide, fits, grp_ok, spill;

   assign need   = CW'(uops_i);
   assign wide   = (need > WIDTH_C);
   assign fits   = (need <= bw_i) || wide;
   assign grp_ok = !begin_i || (iss_i == '0);
   assign acc_o  = go_i && valid_i && fits && grp_ok;
   assign spill  = acc_o && (need > bw_i);

   always_comb begin
      if (!acc_o) begin
         bw_o  = bw_i;
         iss_o = iss_i;
      end else if (spill) begin
         bw_o  = '0;
         iss_o = iss_i + bw_i;
      end else begin
         bw_o  = end_i ? '0 : (bw_i - need);
         iss_o = iss_i + need;
      end
   end

   assign go_o        = acc_o && !spill;
   assign spill_o     = spill;
   assign spill_cnt_o = spill ? UOPW'(need - bw_i) : '0;
   assign spill_end_o = spill && end_i;

   // R4: only an instruction wider than the issue width may spill
   p_spill_only_wide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spill_o |-> (CW'(uops_i) > WIDTH_C));
   // R6: the budget handed on never grows across a lane
   p_budget_monotone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bw_o <= bw_i);

endmodule

// File: rtl/issue_slot_ctrl.sv
module issue_slot_ctrl
   import issue_slot_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned SLOTS = 4,
   parameter int unsigned UOPW  = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  stall_i,
   input  logic [SLOTS-1:0]      in_valid_i,
   input  logic [SLOTS*UOPW-1:0] in_uops_i,
   input  logic [SLOTS-1:0]      in_begin_i,
   input  logic [SLOTS-1:0]      in_end_i,
   output logic [SLOTS-1:0]      accept_o,
   output logic                  carry_busy_o,
   output logic                  carry_done_o,
   output logic                  overflow_o
);

   localparam int unsigned BWW = slot_clog2(WIDTH + 1);
   localparam int unsigned CW  = slot_max(UOPW, BWW) + 1;
   localparam logic [CW-1:0] WIDTH_C = CW'(WIDTH);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("issue_slot_ctrl: WIDTH must be at least 1");
      end
      if (SLOTS < 1) begin : g_bad_slots
         $error("issue_slot_ctrl: SLOTS must be at least 1");
      end
      if (UOPW < 1) begin : g_bad_uopw
         $error("issue_slot_ctrl: UOPW must be at least 1");
      end
   endgenerate

   logic [SLOTS:0]            go_c;
   logic [SLOTS:0][CW-1:0]    bw_c;
   logic [SLOTS:0][CW-1:0]    iss_c;
   logic [SLOTS-1:0]          spill_v;
   logic [SLOTS-1:0]          spill_end_v;
   logic [SLOTS-1:0][UOPW-1:0] spill_cnt_v;

   logic            co_busy, co_done, co_hold;
   logic [CW-1:0]   co_bw;
   logic            new_vld, new_end;
   logic [UOPW-1:0] new_cnt;

   issue_slot_carry #(
      .WIDTH(WIDTH), .UOPW(UOPW), .CW(CW)
   ) u_carry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .new_vld_i (new_vld),
      .new_cnt_i (new_cnt),
      .new_end_i (new_end),
      .busy_o    (co_busy),
      .done_o    (co_done),
      .hold_o    (co_hold),
      .bw_o      (co_bw)
   );

   // Head of the lane chain: carry drain first, then stall gating
   assign go_c[0]  = !stall_i && !co_hold;
   assign bw_c[0]  = stall_i ? '0 : co_bw;
   assign iss_c[0] = '0;

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_lane
         issue_slot_lane #(
            .WIDTH(WIDTH), .UOPW(UOPW), .CW(CW)
         ) u_lane (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .go_i        (go_c[i]),
            .valid_i     (in_valid_i[i]),
            .uops_i      (in_uops_i[i*UOPW +: UOPW]),
            .begin_i     (in_begin_i[i]),
            .end_i       (in_end_i[i]),
            .bw_i        (bw_c[i]),
            .iss_i       (iss_c[i]),
            .acc_o       (accept_o[i]),
            .go_o        (go_c[i+1]),
            .bw_o        (bw_c[i+1]),
            .iss_o       (iss_c[i+1]),
            .spill_o     (spill_v[i]),
            .spill_cnt_o (spill_cnt_v[i]),
            .spill_end_o (spill_end_v[i])
         );
         if (i > 0) begin : g_order
            // R11: a lane is accepted only behind an accepted older lane
            p_in_order_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
               accept_o[i] |-> accept_o[i-1]);
         end
      end
   endgenerate

   // At most one lane spills; merge its record by OR
   always_comb begin
      new_cnt = '0;
      for (int i = 0; i < SLOTS; i++) begin
         new_cnt = new_cnt | spill_cnt_v[i];
      end
   end
   assign new_vld = |spill_v;
   assign new_end = |spill_end_v;

   assign carry_busy_o = co_busy;
   assign carry_done_o = co_done;
   assign overflow_o   = (iss_c[SLOTS] > WIDTH_C);

   // R13: the issued count never exceeds the width
   p_no_overflow_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !overflow_o);
   // R2: stall blocks every lane
   p_stall_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i |-> (accept_o == '0));
   // R8: a held carry blocks every lane
   p_hold_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (carry_busy_o && !carry_done_o) |-> (accept_o == '0));
   // R7: a spill leaves a carry pending in the next cycle
   p_spill_pends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      new_vld |=> carry_busy_o);
   // R10: completion is only reported for a pending carry
   p_done_needs_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      carry_done_o |-> carry_busy_o);
   // R11: an unbroken chain means every lane was accepted
   p_chain_all_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_c[SLOTS] |-> (&accept_o));
   // R6: remaining budget never exceeds the width
   p_budget_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bw_c[SLOTS] <= WIDTH_C);
   // R12: stall does not freeze a held carry
   p_stall_drains_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_i && carry_busy_o && !carry_done_o) |=> carry_busy_o);

endmodule

// File: tb/sim_issue_slot_ctrl.sv
module sim_issue_slot_ctrl;

   localparam int W  = 4;
   localparam int S  = 4;
   localparam int UW = 4;
   localparam int NROWS = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall;
   logic [S-1:0]  valid, beg, fin;
   logic [S*UW-1:0] uops;
   logic [S-1:0]  acc;
   logic          busy, done, ovf;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   issue_slot_ctrl #(.WIDTH(W), .SLOTS(S), .UOPW(UW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
      .in_valid_i(valid), .in_uops_i(uops), .in_begin_i(beg), .in_end_i(fin),
      .accept_o(acc), .carry_busy_o(busy), .carry_done_o(done), .overflow_o(ovf)
   );

   // Row: {stall, valid[4], uops[16] (lane i at nibble i), begin[4], end[4],
   //       expected accept[4], expected busy, expected done}
   localparam logic [34:0] ROWS [NROWS] = '{
      {1'b0, 4'b1111, 16'h1111, 4'b0000, 4'b0000, 4'b1111, 1'b0, 1'b0}, // 0  R1
      {1'b0, 4'b0011, 16'h0032, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // 1  R3
      {1'b0, 4'b0111, 16'h0121, 4'b0000, 4'b0010, 4'b0011, 1'b0, 1'b0}, // 2  R6
      {1'b0, 4'b0011, 16'h0011, 4'b0010, 4'b0000, 4'b0001, 1'b0, 1'b0}, // 3  R5
      {1'b0, 4'b0011, 16'h0022, 4'b0001, 4'b0000, 4'b0011, 1'b0, 1'b0}, // 4  R5
      {1'b0, 4'b0111, 16'h0162, 4'b0000, 4'b0000, 4'b0011, 1'b0, 1'b0}, // 5  R7
      {1'b0, 4'b0001, 16'h0001, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1}, // 6  R10
      {1'b0, 4'b0001, 16'h0001, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // 7  R1
      {1'b0, 4'b0001, 16'h000A, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // 8  R4
      {1'b0, 4'b0001, 16'h0001, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0}, // 9  R8
      {1'b0, 4'b0011, 16'h0012, 4'b0000, 4'b0000, 4'b0001, 1'b1, 1'b1}, // 10 R9
      {1'b0, 4'b0001, 16'h0006, 4'b0000, 4'b0001, 4'b0001, 1'b0, 1'b0}, // 11 R6
      {1'b0, 4'b0001, 16'h0001, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1}, // 12 R9
      {1'b1, 4'b0001, 16'h0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // 13 R2
      {1'b0, 4'b0001, 16'h0005, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // 14 R4
      {1'b0, 4'b0001, 16'h0001, 4'b0001, 4'b0000, 4'b0001, 1'b1, 1'b1}, // 15 R5
      {1'b0, 4'b0010, 16'h0010, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // 16 R11
      {1'b0, 4'b0011, 16'h0051, 4'b0000, 4'b0001, 4'b0011, 1'b0, 1'b0}, // 17 R4
      {1'b0, 4'b0000, 16'h0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0}, // 18 R8
      {1'b0, 4'b0000, 16'h0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1}, // 19 R10
      {1'b0, 4'b0001, 16'h0004, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // 20 R3
      {1'b0, 4'b0001, 16'h0007, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // 21 R7
      {1'b1, 4'b0001, 16'h0001, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1}, // 22 R12
      {1'b0, 4'b0000, 16'h0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}  // 23 R12
   };

   function automatic string row_req(input int r);
      case (r)
         0, 7:          return "R1";
         1, 20:         return "R3";
         2, 11:         return "R6";
         3, 4, 15:      return "R5";
         5, 21:         return "R7";
         6, 19:         return "R10";
         8, 14, 17:     return "R4";
         9, 18:         return "R8";
         10, 12:        return "R9";
         13:            return "R2";
         16:            return "R11";
         default:       return "R12";
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      stall = 1'b0; valid = '0; uops = '0; beg = '0; fin = '0;
   endtask

   initial begin
      idle_inputs();
      #1;
      // R14: reset state
      check("R14", "busy in reset", int'(busy), 0);
      check("R14", "done in reset", int'(done), 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk
      for (int r = 0; r < NROWS; r++) begin
         @(negedge clk);
         stall = ROWS[r][34];
         valid = ROWS[r][33:30];
         uops  = ROWS[r][29:14];
         beg   = ROWS[r][13:10];
         fin   = ROWS[r][9:6];
         #1;
         check(row_req(r), $sformatf("row %0d accept", r), int'(acc), int'(ROWS[r][5:2]));
         check(row_req(r), $sformatf("row %0d busy", r), int'(busy), int'(ROWS[r][1]));
         check(row_req(r), $sformatf("row %0d done", r), int'(done), int'(ROWS[r][0]));
         check("R13", $sformatf("row %0d overflow", r), int'(ovf), 0);
      end

      // R14: reset in the middle of a carry-over
      @(negedge clk);
      idle_inputs();
      valid = 4'b0001; uops = 16'h000F;
      #1;
      check("R14", "wide accept before reset", int'(acc), 1);
      @(negedge clk);
      idle_inputs();
      #1;
      check("R14", "carry pending before reset", int'(busy), 1);
      rst_n = 1'b0;
      #1;
      check("R14", "busy cleared by reset", int'(busy), 0);
      check("R14", "done cleared by reset", int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R14", "busy after reset release", int'(busy), 0);

      // R4: wide instruction into a closed cycle (budget zero) is still taken
      @(negedge clk);
      valid = 4'b0011; uops = 16'h0051; fin = 4'b0001;
      #1;
      check("R4", "wide after end-group", int'(acc), 3);
      @(negedge clk);
      idle_inputs();
      valid = 4'b1111; uops = 16'h1111;
      #1;
      check("R8", "carry of 5 holds cycle", int'(acc), 0);
      @(negedge clk);
      #1;
      // carry of 1 drains, 3 slots remain for lanes
      check("R9", "leftover slots after drain", int'(acc), 4'b0111);
      check("R10", "drain pulse", int'(done), 1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule